// File: doc/BRIEF.md
# Vertical Timing and Start-of-Frame Generator

This block is the vertical half of a display timing generator. A line-rate tick from the horizontal side moves a line counter from 0 up to a programmable vertical total, and each wrap back to the top advances a 24-bit frame counter. From the current line, the block derives three outputs: a vertical blanking flag, a start-of-frame pulse and an advanced-start-line pulse.

The start-of-frame pulse falls a few lines before blanking ends. The exact line depends on the scan mode, on whether the scaler is in use and on an early-start control for each mode. In interlaced mode, the counter steps by two lines per tick. An even/odd field flag picks the starting parity and the per-field offset.

A packed status word carries the low frame bits and the current line together, so one access reads a consistent pair. Driving the enable input low clears all state and silences every pulse.

Top module: `vtg_sof_gen`

## Requirements
- R1: In progressive mode (interlace_i=0), each line_tick_i while enabled adds 1 to line_o. When the result would reach vtotal_i, line_o returns to 0 instead, so the line after vtotal_i-1 is 0.
- R2: frame_o (24 bits) increases by 1 on every wrap of the line counter and is unchanged on every other tick.
- R3: In interlaced mode, each tick adds 2 to line_o. On a wrap, field_o toggles. The new field starts at line 0 when field_o=0 (even) and at line 1 when field_o=1 (odd). In progressive mode field_o stays 0.
- R4: vblank_o is high while enabled when line_o >= vblank_start_i or line_o < vblank_end_i, and low otherwise.
- R5: In progressive mode without the early condition, sof_o pulses for exactly one clock, in the clock after the tick that moves line_o to vblank_end_i-2.
- R6: In progressive mode, when scaler_en_i=1 and prog_early_i=1 together, the pulse moves to line vblank_end_i-3. Either bit alone leaves it at vblank_end_i-2.
- R7: In interlaced mode without the early condition, sof_o pulses at line vblank_end_i-4 in the even field (field_o=0) and at vblank_end_i-3 in the odd field (field_o=1).
- R8: In interlaced mode, when scaler_en_i=1 and intl_early_i=1 together, the pulse lines become vblank_end_i-6 (even field) and vblank_end_i-5 (odd field).
- R9: adv_sol_o pulses for one clock, in the clock after the tick that moves line_o to vblank_end_i-adv_pos_i.
- R10: status_o holds frame_o[15:0] in bits 28:13 and line_o in bits 12:0, taken from the same cycle.
- R11: While enable_i=0, line_o, field_o and frame_o are 0 and vblank_o, sof_o and adv_sol_o stay low. Ticks during this time have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Generator enable; low clears state |
| line_tick_i | input | 1 | One-clock pulse per horizontal line |
| interlace_i | input | 1 | 1 = interlaced, count by 2 per line |
| scaler_en_i | input | 1 | Scaler in use |
| prog_early_i | input | 1 | Early start-of-frame, progressive |
| intl_early_i | input | 1 | Early start-of-frame, interlaced |
| adv_pos_i | input | 4 | Lines before blank end for adv_sol_o |
| vtotal_i | input | 13 | Lines per frame |
| vblank_start_i | input | 13 | First blanked line |
| vblank_end_i | input | 13 | First visible line |
| vblank_o | output | 1 | Vertical blank flag |
| sof_o | output | 1 | Start-of-frame pulse |
| adv_sol_o | output | 1 | Advanced start-line pulse |
| line_o | output | 13 | Current line |
| field_o | output | 1 | Current field, 1 = odd |
| frame_o | output | 24 | Frame count |
| status_o | output | 29 | {frame_o[15:0], line_o} |

## Verification
The bench goes after the wrap from vtotal-1. A design that compared against vtotal-2 or vtotal would show a frame of the wrong length, and the frame counter would step at the wrong tick. The early controls are driven singly and in pairs. A design that moved the pulse on the early bit alone, or that used the wrong mode's bit, would pulse one line off. Interlaced runs cover both fields over several frames. A design with swapped field offsets or start parity would never hit its pulse line, or would hit it in the wrong field. Ticks sent while disabled catch any design that keeps counting or leaks a pulse.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  parameter int LINE_W_DEF  = 13;
  parameter int FRAME_W_DEF = 24;
  parameter int STAT_FR_DEF = 16;

  // lines before blank end at which start-of-frame fires
  function automatic logic [2:0] sof_offset(input logic intl, input logic odd, input logic early);
    logic [2:0] base;
    if (!intl) base = early ? 3'd3 : 3'd2;
    else       base = (odd ? 3'd3 : 3'd4) + (early ? 3'd2 : 3'd0);
    return base;
  endfunction
endpackage

// File: rtl/vtg_line_ctr.sv
module vtg_line_ctr #(
  parameter int LINE_W  = 13,
  parameter int FRAME_W = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               enable_i,
  input  logic               tick_i,
  input  logic               interlace_i,
  input  logic [LINE_W-1:0]  vtotal_i,
  output logic [LINE_W-1:0]  line_o,
  output logic               field_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic               new_line_o
);
  logic [LINE_W-1:0]  line_q;
  logic               field_q;
  logic [FRAME_W-1:0] frame_q;
  logic               new_line_q;
  logic [LINE_W:0]    nxt;
  logic               wrap;

  assign nxt  = {1'b0, line_q} + (interlace_i ? (LINE_W+1)'(2) : (LINE_W+1)'(1));
  assign wrap = nxt >= {1'b0, vtotal_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q     <= '0;
      field_q    <= 1'b0;
      frame_q    <= '0;
      new_line_q <= 1'b0;
    end else if (!enable_i) begin
      line_q     <= '0;
      field_q    <= 1'b0;
      frame_q    <= '0;
      new_line_q <= 1'b0;
    end else begin
      new_line_q <= tick_i;
      if (tick_i) begin
        if (wrap) begin
          frame_q <= frame_q + 1'b1;
          if (interlace_i) begin
            field_q <= ~field_q;
            line_q  <= {{(LINE_W-1){1'b0}}, ~field_q};
          end else begin
            field_q <= 1'b0;
            line_q  <= '0;
          end
        end else begin
          line_q <= nxt[LINE_W-1:0];
        end
      end
    end
  end

  assign line_o     = line_q;
  assign field_o    = field_q;
  assign frame_o    = frame_q;
  assign new_line_o = new_line_q;

  assert_wrap_top_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && tick_i && wrap) |=> (line_q <= 1));
  assert_frame_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && !(tick_i && wrap)) |=> (!enable_i || $stable(frame_q)) || $past(!enable_i) || (frame_q == '0));
  assert_field_toggle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && interlace_i && tick_i && wrap) |=> (field_q != $past(field_q)) && (line_q[0] == field_q));
  assert_disabled_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (line_q == '0 && frame_q == '0 && !field_q && !new_line_q));
endmodule

// File: rtl/vtg_pulse_dec.sv
module vtg_pulse_dec
  import vtg_pkg::*;
#(
  parameter int LINE_W = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              new_line_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic              field_i,
  input  logic              interlace_i,
  input  logic              scaler_en_i,
  input  logic              prog_early_i,
  input  logic              intl_early_i,
  input  logic [3:0]        adv_pos_i,
  input  logic [LINE_W-1:0] vblank_start_i,
  input  logic [LINE_W-1:0] vblank_end_i,
  output logic              vblank_o,
  output logic              sof_o,
  output logic              adv_sol_o
);
  logic              early;
  logic [LINE_W-1:0] sof_line;
  logic [LINE_W-1:0] adv_line;

  assign early    = scaler_en_i && (interlace_i ? intl_early_i : prog_early_i);
  assign sof_line = vblank_end_i - LINE_W'(sof_offset(interlace_i, field_i, early));
  assign adv_line = vblank_end_i - LINE_W'(adv_pos_i);

  assign vblank_o  = enable_i && ((line_i >= vblank_start_i) || (line_i < vblank_end_i));
  assign sof_o     = enable_i && new_line_i && (line_i == sof_line);
  assign adv_sol_o = enable_i && new_line_i && (line_i == adv_line);

  assert_quiet_off_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |-> !(sof_o || adv_sol_o || vblank_o));
  assert_sof_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |=> !sof_o);
  assert_adv_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_sol_o |=> !adv_sol_o);
endmodule

// File: rtl/vtg_sof_gen.sv
module vtg_sof_gen
  import vtg_pkg::*;
#(
  parameter int LINE_W  = LINE_W_DEF,
  parameter int FRAME_W = FRAME_W_DEF,
  parameter int STAT_FR = STAT_FR_DEF
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      enable_i,
  input  logic                      line_tick_i,
  input  logic                      interlace_i,
  input  logic                      scaler_en_i,
  input  logic                      prog_early_i,
  input  logic                      intl_early_i,
  input  logic [3:0]                adv_pos_i,
  input  logic [LINE_W-1:0]         vtotal_i,
  input  logic [LINE_W-1:0]         vblank_start_i,
  input  logic [LINE_W-1:0]         vblank_end_i,
  output logic                      vblank_o,
  output logic                      sof_o,
  output logic                      adv_sol_o,
  output logic [LINE_W-1:0]         line_o,
  output logic                      field_o,
  output logic [FRAME_W-1:0]        frame_o,
  output logic [STAT_FR+LINE_W-1:0] status_o
);
  logic new_line;

  vtg_line_ctr #(.LINE_W(LINE_W), .FRAME_W(FRAME_W)) u_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .enable_i   (enable_i),
    .tick_i     (line_tick_i),
    .interlace_i(interlace_i),
    .vtotal_i   (vtotal_i),
    .line_o     (line_o),
    .field_o    (field_o),
    .frame_o    (frame_o),
    .new_line_o (new_line)
  );

  vtg_pulse_dec #(.LINE_W(LINE_W)) u_dec (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .enable_i      (enable_i),
    .new_line_i    (new_line),
    .line_i        (line_o),
    .field_i       (field_o),
    .interlace_i   (interlace_i),
    .scaler_en_i   (scaler_en_i),
    .prog_early_i  (prog_early_i),
    .intl_early_i  (intl_early_i),
    .adv_pos_i     (adv_pos_i),
    .vblank_start_i(vblank_start_i),
    .vblank_end_i  (vblank_end_i),
    .vblank_o      (vblank_o),
    .sof_o         (sof_o),
    .adv_sol_o     (adv_sol_o)
  );

  // both fields captured from the same registers in the same cycle
  assign status_o = {frame_o[STAT_FR-1:0], line_o};
endmodule

// File: tb/vtg_sof_gen_tb.sv
module vtg_sof_gen_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        en = 0, tick = 0, intl = 0, scl = 0, pe = 0, ie = 0;
  logic [3:0]  adv = 4'd4;
  logic [12:0] vt = 13'd20, vbs = 13'd16, vbe = 13'd6;
  logic        vblank, sof, advp, field;
  logic [12:0] line;
  logic [23:0] frame;
  logic [28:0] status;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;
  int e_line = 0, e_frame = 0;
  bit e_field = 0;

  always #5 clk = ~clk;

  vtg_sof_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .line_tick_i(tick),
    .interlace_i(intl), .scaler_en_i(scl), .prog_early_i(pe), .intl_early_i(ie),
    .adv_pos_i(adv), .vtotal_i(vt), .vblank_start_i(vbs), .vblank_end_i(vbe),
    .vblank_o(vblank), .sof_o(sof), .adv_sol_o(advp), .line_o(line),
    .field_o(field), .frame_o(frame), .status_o(status)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      failures++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sof_off();
    if (!intl) return (scl && pe) ? 3 : 2;
    return (e_field ? 3 : 4) + ((scl && ie) ? 2 : 0);
  endfunction

  // full output check against the bench model; pulse flag = sampled after a tick
  task automatic check_all(input string sreq, input bit after_tick);
    bit exp_sof, exp_adv, exp_vb;
    exp_vb  = en && (e_line >= vbs || e_line < vbe);
    exp_sof = en && after_tick && (e_line == int'(vbe) - sof_off());
    exp_adv = en && after_tick && (e_line == int'(vbe) - int'(adv));
    chk(intl ? "R3 line" : "R1 line", line, e_line);
    chk("R3 field", field, e_field);
    chk("R2 frame", frame, e_frame);
    chk("R10 status", status, {e_frame[15:0], e_line[12:0]});
    chk("R4 vblank", vblank, exp_vb);
    chk(sreq, sof, exp_sof);
    chk("R9 adv_sol", advp, exp_adv);
  endtask

  task automatic step_line(input string sreq);
    int nxt;
    @(negedge clk) tick = 1;
    @(negedge clk) tick = 0;
    if (en) begin
      nxt = e_line + (intl ? 2 : 1);
      if (nxt >= vt) begin
        e_frame++;
        if (intl) begin e_field = ~e_field; e_line = e_field; end
        else begin e_field = 0; e_line = 0; end
      end else e_line = nxt;
    end
    check_all(sreq, 1);
    @(negedge clk);
    chk(sreq, sof, 0);
  endtask

  task automatic restart();
    @(negedge clk) en = 0;
    @(negedge clk) en = 1;
    e_line = 0; e_field = 0; e_frame = 0;
  endtask

  task automatic run_lines(input string sreq, input int n);
    for (int i = 0; i < n; i++) step_line(sreq);
  endtask

  task automatic test_reset();
    @(negedge clk);
    check_all("R11 reset", 0);
  endtask

  task automatic test_progressive();
    intl = 0; scl = 0; pe = 0; adv = 4'd4; restart();
    run_lines("R5 sof progressive", 45);
    chk("R2 frame after 45 lines", frame, 2);
  endtask

  task automatic test_prog_early();
    intl = 0; scl = 1; pe = 1; adv = 4'd1; restart();
    run_lines("R6 sof early", 42);
    scl = 0; pe = 1; restart();
    run_lines("R6 early bit alone", 21);
    scl = 1; pe = 0; ie = 1; restart();
    run_lines("R6 scaler alone", 21);
    ie = 0;
  endtask

  task automatic test_interlace();
    intl = 1; scl = 0; ie = 0; adv = 4'd4; restart();
    run_lines("R7 sof interlaced", 45);
    chk("R3 field after 4 wraps", field, 0);
  endtask

  task automatic test_intl_early();
    intl = 1; scl = 1; ie = 1; pe = 0; adv = 4'd5; restart();
    run_lines("R8 sof interlaced early", 45);
    ie = 0; pe = 1; restart();
    run_lines("R8 prog bit in interlace", 22);
    pe = 0;
  endtask

  task automatic test_disable();
    intl = 0; scl = 0; restart();
    run_lines("R5 sof", 25);
    @(negedge clk) en = 0;
    e_line = 0; e_frame = 0; e_field = 0;
    run_lines("R11 sof while disabled", 10);
    chk("R11 line held", line, 0);
    chk("R11 vblank low", vblank, 0);
  endtask

  task automatic test_short_frame();
    intl = 0; vt = 13'd8; vbs = 13'd6; vbe = 13'd3; adv = 4'd2; restart();
    run_lines("R5 sof short frame", 30);
    vt = 13'd20; vbs = 13'd16; vbe = 13'd6;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    test_reset();
    test_progressive();
    test_prog_early();
    test_interlace();
    test_intl_early();
    test_short_frame();
    test_disable();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule